// File: doc/BRIEF.md
# Word-Aligned Next-PC Unit

This block holds a processor's program counter and works out the value it takes on the next clock edge. Instruction addresses are always word-aligned, so the unit stores only the upper 30 bits of the address. The two low bits of the output are tied to zero. The incrementer and the target adders therefore work on a word count, not on byte addresses.

Each cycle the unit picks one of three next values:

- **Sequential:** the next word, which is the current PC plus 4 in byte terms.
- **Relative branch:** the next word plus a 16-bit signed word offset.
- **Absolute jump:** the top four bits of the next-word address, followed by a 26-bit word index and two zero bits.

A jump is taken whenever it is requested. A branch-if-equal is taken when the ALU zero flag is high, and a branch-if-not-equal when it is low. An advance enable lets the surrounding pipeline hold the PC in place. A synchronous reset returns the PC to address zero.

All inputs are plain control and data levels sampled on the rising clock edge. The unit has no streaming interface, so there is no back-pressure; holding the PC is done through the enable alone.

Top module: `next_pc_unit`

## Requirements
- R1: The two least significant bits of `pc_out` are 0 in every cycle.
- R2: With `adv_en` high and no redirect, `pc_out` increases by 4 at the next rising edge.
- R3: A taken branch loads `pc_out + 4 + (sign-extended imm_br * 4)`. Bit 15 of `imm_br` is the sign bit.
- R4: With `do_jump` high, the next PC is built from three fields. Bits 31:28 come from `pc_out + 4`. Bits 27:2 are `imm_jmp[25:0]`. Bits 1:0 are 0.
- R5: `br_eq` alone redirects only when `alu_zero` is 1. `br_ne` alone redirects only when `alu_zero` is 0. Otherwise the PC advances sequentially.
- R6: When `do_jump` is high, the jump target is used whatever the branch inputs and `alu_zero` are.
- R7: With `adv_en` low, `pc_out` keeps its value across the edge, whatever the other inputs are.
- R8: `rst` high at a rising edge loads `pc_out` with 0x00000000. Reset takes priority over `adv_en` and over all redirect inputs.
- R9: Address arithmetic wraps modulo 2^32. Advancing from 0xFFFFFFFC yields 0x00000000, and a negative branch offset from a low address wraps to the top of the space.
- R10: With `br_eq` and `br_ne` both high and `do_jump` low, the branch is taken whatever `alu_zero` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | PC update enable; low holds the PC |
| imm_br | input | 16 | Signed branch offset in words |
| imm_jmp | input | 26 | Absolute jump word index |
| do_jump | input | 1 | Unconditional jump request |
| br_eq | input | 1 | Branch when the operands are equal |
| br_ne | input | 1 | Branch when the operands differ |
| alu_zero | input | 1 | ALU zero flag from the compare |
| pc_out | output | 32 | Current byte address of the instruction |

## Verification
The assertions assume the following about the inputs:

- All inputs are stable and known at each rising edge.
- `alu_zero` is meaningful only in cycles where a branch request is present.
- The reset is held for at least one edge before anything else is checked.

The stimulus respects these assumptions by changing inputs only at the falling edge. Control combinations are drawn at random, including the illegal-looking overlaps of jump and both branch kinds, so that the priority rules are exercised. Directed sequences reach the wrap-around boundary with a negative branch from address zero.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } npc_src_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int WORD_W = 30,
  parameter int BR_W   = 16,
  parameter int JMP_W  = 26
) (
  input  logic [WORD_W-1:0] word_pc,
  input  logic [BR_W-1:0]   imm_br,
  input  logic [JMP_W-1:0]  imm_jmp,
  output logic [WORD_W-1:0] inc_w,
  output logic [WORD_W-1:0] br_w,
  output logic [WORD_W-1:0] jmp_w
);
  localparam int SEXT_W = WORD_W - BR_W;
  localparam int JHI_W  = WORD_W - JMP_W;

  logic [WORD_W-1:0] br_off;

  assign inc_w  = word_pc + WORD_W'(1);
  assign br_off = {{SEXT_W{imm_br[BR_W-1]}}, imm_br};
  assign br_w   = inc_w + br_off;

  generate
    if (JHI_W > 0) begin : g_region
      assign jmp_w = {inc_w[WORD_W-1 -: JHI_W], imm_jmp};
    end else begin : g_flat
      assign jmp_w = imm_jmp[WORD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  logic     do_jump,
  input  logic     br_eq,
  input  logic     br_ne,
  input  logic     alu_zero,
  output npc_src_e src
);
  logic br_taken;

  always_comb begin
    br_taken = (br_eq & alu_zero) | (br_ne & ~alu_zero);
    if (do_jump)       src = SRC_JUMP;
    else if (br_taken) src = SRC_BRANCH;
    else               src = SRC_SEQ;
  end
endmodule

// File: rtl/npc_word_reg.sv
module npc_word_reg
  import npc_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  npc_src_e          src,
  input  logic [WORD_W-1:0] inc_w,
  input  logic [WORD_W-1:0] br_w,
  input  logic [WORD_W-1:0] jmp_w,
  output logic [WORD_W-1:0] word_pc
);
  logic [WORD_W-1:0] next_w;

  always_comb begin
    unique case (src)
      SRC_JUMP:   next_w = jmp_w;
      SRC_BRANCH: next_w = br_w;
      default:    next_w = inc_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     word_pc <= '0;
    else if (en) word_pc <= next_w;
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int BR_W       = 16,
  parameter int JMP_W      = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_en,
  input  logic [BR_W-1:0]  imm_br,
  input  logic [JMP_W-1:0] imm_jmp,
  input  logic             do_jump,
  input  logic             br_eq,
  input  logic             br_ne,
  input  logic             alu_zero,
  output logic [PC_W-1:0]  pc_out
);
  localparam int WORD_W = PC_W - ALIGN_BITS;

  logic [WORD_W-1:0] word_pc;
  logic [WORD_W-1:0] inc_w;
  logic [WORD_W-1:0] br_w;
  logic [WORD_W-1:0] jmp_w;
  npc_src_e          src;

  npc_targets #(
    .WORD_W(WORD_W),
    .BR_W  (BR_W),
    .JMP_W (JMP_W)
  ) u_targets (
    .word_pc(word_pc),
    .imm_br (imm_br),
    .imm_jmp(imm_jmp),
    .inc_w  (inc_w),
    .br_w   (br_w),
    .jmp_w  (jmp_w)
  );

  npc_select u_select (
    .do_jump (do_jump),
    .br_eq   (br_eq),
    .br_ne   (br_ne),
    .alu_zero(alu_zero),
    .src     (src)
  );

  npc_word_reg #(
    .WORD_W(WORD_W)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .en     (adv_en),
    .src    (src),
    .inc_w  (inc_w),
    .br_w   (br_w),
    .jmp_w  (jmp_w),
    .word_pc(word_pc)
  );

  assign pc_out = {word_pc, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int BR_W       = 16,
  parameter int JMP_W      = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             adv_en,
  input logic [BR_W-1:0]  imm_br,
  input logic [JMP_W-1:0] imm_jmp,
  input logic             do_jump,
  input logic             br_eq,
  input logic             br_ne,
  input logic             alu_zero,
  input logic [PC_W-1:0]  pc_out
);
  localparam int JHI = PC_W - ALIGN_BITS - JMP_W;
  localparam int SX  = PC_W - BR_W - ALIGN_BITS;

  logic [PC_W-1:0] inc_c, off_c, jt_c;
  logic            take_c;

  assign inc_c  = pc_out + (PC_W'(1) << ALIGN_BITS);
  assign off_c  = {{SX{imm_br[BR_W-1]}}, imm_br, {ALIGN_BITS{1'b0}}};
  assign jt_c   = {inc_c[PC_W-1 -: JHI], imm_jmp, {ALIGN_BITS{1'b0}}};
  assign take_c = (br_eq && alu_zero) || (br_ne && !alu_zero);

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> pc_out == '0);  // R8
  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_out[ALIGN_BITS-1:0] == '0);  // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_out));  // R7
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    adv_en && !do_jump && !take_c |=> pc_out == $past(inc_c));  // R2
  AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
    adv_en && !do_jump && take_c |=> pc_out == $past(inc_c + off_c));  // R3
  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    adv_en && do_jump |=> pc_out == $past(jt_c));  // R4
  AST_DUAL_BR: assert property (@(posedge clk) disable iff (rst)
    adv_en && !do_jump && br_eq && br_ne |=> pc_out == $past(inc_c + off_c));  // R10
endmodule

bind next_pc_unit npc_checker #(
  .PC_W      (PC_W),
  .ALIGN_BITS(ALIGN_BITS),
  .BR_W      (BR_W),
  .JMP_W     (JMP_W)
) i_npc_checker (
  .clk     (clk),
  .rst     (rst),
  .adv_en  (adv_en),
  .imm_br  (imm_br),
  .imm_jmp (imm_jmp),
  .do_jump (do_jump),
  .br_eq   (br_eq),
  .br_ne   (br_ne),
  .alu_zero(alu_zero),
  .pc_out  (pc_out)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [15:0] imm_br = '0;
  logic [25:0] imm_jmp = '0;
  logic        do_jump = 1'b0;
  logic        br_eq = 1'b0;
  logic        br_ne = 1'b0;
  logic        alu_zero = 1'b0;
  logic [31:0] pc_out;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic [31:0] model_pc = '0;

  always #2.5 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .clk(clk), .rst(rst), .adv_en(adv_en), .imm_br(imm_br), .imm_jmp(imm_jmp),
    .do_jump(do_jump), .br_eq(br_eq), .br_ne(br_ne), .alu_zero(alu_zero),
    .pc_out(pc_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pc_out=%08h expected %08h", req, act, exp);
    end
  endtask

  // Behavioural reference: byte-address arithmetic on 32-bit unsigned values.
  function automatic logic [31:0] ref_next(input logic [31:0] cur);
    logic [31:0] seq;
    int          off;
    bit          take;
    if (rst) return 32'h0;
    if (!adv_en) return cur;
    seq  = cur + 32'd4;
    off  = int'($signed(imm_br)) * 4;
    take = (br_eq && alu_zero) || (br_ne && !alu_zero);
    if (do_jump) return (seq & 32'hF000_0000) | (32'(imm_jmp) * 4);
    if (take) return seq + 32'(off);
    return seq;
  endfunction

  function automatic string classify();
    if (rst) return "R8";
    if (!adv_en) return "R7";
    if (do_jump) return (br_eq || br_ne) ? "R6" : "R4";
    if (br_eq && br_ne) return "R10";
    if (br_eq || br_ne) return ((br_eq && alu_zero) || (br_ne && !alu_zero)) ? "R3" : "R5";
    return "R2";
  endfunction

  // Inputs are already set at a falling edge; advance one cycle and compare.
  task automatic step(input string tag_override = "");
    logic [31:0] exp;
    string       tag;
    exp = ref_next(model_pc);
    tag = (tag_override != "") ? tag_override : classify();
    @(posedge clk);
    @(negedge clk);
    model_pc = exp;
    check(tag, pc_out, exp);
    check("R1", {30'd0, pc_out[1:0]}, 32'd0);
  endtask

  task automatic drive(input bit en, input bit j, input bit be, input bit bn,
                       input bit z, input logic [15:0] ib, input logic [25:0] ij);
    adv_en = en; do_jump = j; br_eq = be; br_ne = bn; alu_zero = z;
    imm_br = ib; imm_jmp = ij;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; drive(1, 1, 1, 1, 1, 16'h7FFF, 26'h3FFFFFF);
    step("R8");
    rst = 1'b0;
    // R2 sequential
    drive(1, 0, 0, 0, 0, 16'h0010, 26'h0); step(); step();
    // R5 not-taken cases
    drive(1, 0, 1, 0, 0, 16'h0010, 26'h0); step();
    drive(1, 0, 0, 1, 1, 16'h0010, 26'h0); step();
    // R3 taken forward and backward
    drive(1, 0, 1, 0, 1, 16'h0020, 26'h0); step();
    drive(1, 0, 0, 1, 0, 16'hFFF0, 26'h0); step();
    // R4 jump
    drive(1, 1, 0, 0, 0, 16'h0, 26'h2ABCDEF); step();
    // R6 jump over a taken branch
    drive(1, 1, 1, 0, 1, 16'h0100, 26'h0000040); step();
    // R10 both branches, either flag
    drive(1, 0, 1, 1, 0, 16'h0004, 26'h0); step();
    drive(1, 0, 1, 1, 1, 16'h0004, 26'h0); step();
    // R7 hold with a redirect pending
    drive(0, 1, 1, 1, 1, 16'h1234, 26'h1111111); step(); step();
    // R8 reset beats enable and jump
    rst = 1'b1; drive(1, 1, 0, 0, 0, 16'h0, 26'h3000000); step("R8");
    rst = 1'b0;
    // R9 wrap: negative branch from 0 lands at 0xFFFFFFFC, then sequential to 0
    drive(1, 0, 1, 0, 1, 16'hFFFE, 26'h0); step("R9");
    check("R9", pc_out, 32'hFFFF_FFFC);
    drive(1, 0, 0, 0, 0, 16'h0, 26'h0); step("R9");
    check("R9", pc_out, 32'h0000_0000);
    // R4 jump region taken from the top of the space
    drive(1, 0, 1, 0, 1, 16'hFFFE, 26'h0); step("R9");
    drive(1, 1, 0, 0, 0, 16'h0, 26'h0000010); step("R4");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0, 1'($urandom),
            1'($urandom), 1'($urandom), 16'($urandom), 26'($urandom));
      if ($urandom_range(0, 49) == 0) rst = 1'b1;
      step();
      rst = 1'b0;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule